// File: doc/BRIEF.md
# L1 Load-Miss Tracking Table

This block sits beside a direct-mapped L1 data cache and takes charge of every load access that misses in it. Rather than answering the miss itself, it keeps the miss in a small table of pending lines. It sends one downstream request per pending line, oldest first, towards address translation and the lower memory levels. Those levels are modelled here as a plain request/response port whose responses carry the entry index as a tag.

When a response arrives, the returned line is written into the L1 tag/data arrays through a fill write port. On the cycle after that write, the block emits a one-cycle replay pulse that gives the access arbiter the warp and lanes to re-issue. Because the line now sits in the cache, that re-issued access hits. A later miss to a line that is already pending joins the existing entry: its lanes are ORed into the entry's lane mask. Store accesses never enter the table, since a separate write buffer handles them.

Top module: `l1_miss_table`

## Requirements
- R1: After reset, miss_ready is 1 and req_valid, fill_we and replay_valid are 0.
- R2: A load miss (miss_is_store=0) accepted while miss_ready is 1, whose line is not already pending, takes the lowest-numbered free entry. From the next cycle it raises req_valid, with req_line set to the line and req_tag set to the entry index. req_valid, req_tag and req_line hold steady until a cycle in which req_ready is 1.
- R3: A load miss to a line that is already pending sends no second downstream request. Its lane mask is ORed into the pending entry's mask.
- R4: With all 4 entries occupied, miss_ready is 0 and an offered miss is not recorded.
- R5: Downstream requests leave in the order in which their entries were allocated.
- R6: A response accepted in cycle T (rsp_valid=1, rsp_tag=k) drives fill_we=1 in cycle T+1. In that cycle fill_line is the line of entry k and fill_data is rsp_data.
- R7: In cycle T+2, replay_valid is 1 for exactly one cycle, with replay_warp and replay_mask taken from entry k. Entry k is free in that same cycle, so miss_ready is 1.
- R8: A miss with miss_is_store=1 allocates no entry and causes no downstream request.
- R9: Responses may arrive in any order and are matched to entries only by rsp_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss offered by the access stage |
| miss_ready | output | 1 | At least one table entry is free |
| miss_is_store | input | 1 | Access is a store; it is not recorded |
| miss_line | input | LINE_AW (26) | Line address of the miss |
| miss_warp | input | WARP_W (5) | Warp identifier |
| miss_mask | input | LANES (32) | Lanes taking part in the access |
| req_valid | output | 1 | Downstream request pending |
| req_ready | input | 1 | Downstream accepts the request |
| req_line | output | LINE_AW (26) | Line address requested |
| req_tag | output | IDX_W (2) | Entry index carried with the request |
| rsp_valid | input | 1 | Response from the lower level |
| rsp_tag | input | IDX_W (2) | Entry index of the response |
| rsp_data | input | DATA_W (128) | Returned line data |
| fill_we | output | 1 | Write strobe to the L1 tag/data arrays |
| fill_line | output | LINE_AW (26) | Line address being filled |
| fill_data | output | DATA_W (128) | Line data being filled |
| replay_valid | output | 1 | One-cycle pulse asking the arbiter to re-issue |
| replay_warp | output | WARP_W (5) | Warp to re-issue |
| replay_mask | output | LANES (32) | Lanes to re-issue |

## Verification
The bench drives inputs on the falling edge and reads outputs on the following falling edges.

- **Requests:** a miss presented before rising edge P is first visible as req_valid after P. The bench therefore reads it on the very next falling edge.
- **Fill:** for a response presented before edge P, the fill write is checked one falling edge later.
- **Replay:** the replay pulse, and the freed entry shown through miss_ready, are checked on the falling edge after that. One further falling edge confirms that the pulse has ended.
- **Absence checks:** checks that something did not happen (stores, merged misses, a stalled miss) look at req_valid across the cycles in which a request would have appeared.

// File: rtl/l1_miss_table.sv
module l1_miss_table #(
  parameter int ENTRIES = 4,
  parameter int LINE_AW = 26,
  parameter int WARP_W  = 5,
  parameter int LANES   = 32,
  parameter int DATA_W  = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic               miss_is_store,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [WARP_W-1:0]  miss_warp,
  input  logic [LANES-1:0]   miss_mask,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [LINE_AW-1:0] req_line,
  output logic [IDX_W-1:0]   req_tag,
  input  logic               rsp_valid,
  input  logic [IDX_W-1:0]   rsp_tag,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               fill_we,
  output logic [LINE_AW-1:0] fill_line,
  output logic [DATA_W-1:0]  fill_data,
  output logic               replay_valid,
  output logic [WARP_W-1:0]  replay_warp,
  output logic [LANES-1:0]   replay_mask
);
  logic [ENTRIES-1:0] vld;
  logic [LINE_AW-1:0] e_line [ENTRIES];
  logic [WARP_W-1:0]  e_warp [ENTRIES];
  logic [LANES-1:0]   e_mask [ENTRIES];

  logic [IDX_W-1:0] q_idx [ENTRIES];
  logic [IDX_W-1:0] q_head, q_tail;
  logic [IDX_W:0]   q_cnt;

  logic [IDX_W-1:0] f_idx, free_idx;
  logic [ENTRIES-1:0] hit_vec;
  logic take, any_hit, do_alloc, do_merge, pop;
  logic [LANES-1:0] merged_mask;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      hit_vec[i] = vld[i] && (e_line[i] == miss_line);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  assign miss_ready = ~&vld;
  assign any_hit    = |hit_vec;
  assign take       = miss_valid && miss_ready && !miss_is_store;
  assign do_alloc   = take && !any_hit;
  assign do_merge   = take && any_hit;

  assign req_valid  = (q_cnt != '0);
  assign req_tag    = q_idx[q_head];
  assign req_line   = e_line[req_tag];
  assign pop        = req_valid && req_ready;

  assign fill_line  = e_line[f_idx];
  assign merged_mask = e_mask[f_idx] | ((do_merge && hit_vec[f_idx]) ? miss_mask : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld          <= '0;
      q_head       <= '0;
      q_tail       <= '0;
      q_cnt        <= '0;
      fill_we      <= 1'b0;
      replay_valid <= 1'b0;
    end else begin
      fill_we      <= rsp_valid;
      replay_valid <= fill_we;
      if (fill_we) vld[f_idx] <= 1'b0;
      if (do_alloc) begin
        vld[free_idx] <= 1'b1;
        q_tail        <= q_tail + 1'b1;
      end
      if (pop) q_head <= q_head + 1'b1;
      q_cnt <= q_cnt + (IDX_W+1)'(do_alloc) - (IDX_W+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid) begin
      f_idx     <= rsp_tag;
      fill_data <= rsp_data;
    end
    if (fill_we) begin
      replay_warp <= e_warp[f_idx];
      replay_mask <= merged_mask;
    end
    if (do_alloc) begin
      e_line[free_idx] <= miss_line;
      e_warp[free_idx] <= miss_warp;
      e_mask[free_idx] <= miss_mask;
      q_idx[q_tail]    <= free_idx;
    end
    for (int i = 0; i < ENTRIES; i++)
      if (do_merge && hit_vec[i]) e_mask[i] <= e_mask[i] | miss_mask;
  end
endmodule

// File: rtl/l1_miss_table_chk.sv
module l1_miss_table_chk #(
  parameter int ENTRIES = 4,
  parameter int LINE_AW = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LINE_AW-1:0] req_line,
  input logic [IDX_W-1:0]   req_tag,
  input logic               rsp_valid,
  input logic               fill_we,
  input logic               replay_valid,
  input logic [ENTRIES-1:0] vld,
  input logic [IDX_W-1:0]   f_idx
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_tag) && $stable(req_line));

  a_r2_req_entry_live: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> vld[req_tag]);

  a_r6_fill_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> $past(rsp_valid));

  a_r7_replay_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> replay_valid);

  a_r7_entry_freed: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> !vld[$past(f_idx)]);
endmodule

bind l1_miss_table l1_miss_table_chk #(.ENTRIES(ENTRIES), .LINE_AW(LINE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .req_tag(req_tag), .rsp_valid(rsp_valid), .fill_we(fill_we),
  .replay_valid(replay_valid), .vld(vld), .f_idx(f_idx)
);

// File: tb/l1_miss_table_tb.sv
module l1_miss_table_tb;
  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, miss_is_store = 0, req_ready = 0, rsp_valid = 0;
  logic [25:0] miss_line = '0;
  logic [4:0] miss_warp = '0;
  logic [31:0] miss_mask = '0;
  logic [1:0] rsp_tag = '0;
  logic [127:0] rsp_data = '0;
  logic miss_ready, req_valid, fill_we, replay_valid;
  logic [25:0] req_line, fill_line;
  logic [1:0] req_tag;
  logic [127:0] fill_data;
  logic [4:0] replay_warp;
  logic [31:0] replay_mask;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  l1_miss_table u_dut (.*);

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_miss(logic [25:0] l, logic [4:0] w, logic [31:0] m, logic st);
    @(negedge clk);
    miss_valid = 1; miss_line = l; miss_warp = w; miss_mask = m; miss_is_store = st;
    @(negedge clk);
    miss_valid = 0; miss_is_store = 0;
  endtask

  task automatic take_req(logic [25:0] l, logic [1:0] tag, string req);
    chk(req, "req_valid", req_valid, 1);
    chk(req, "req_line", req_line, l);
    chk(req, "req_tag", req_tag, tag);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic respond(logic [1:0] tag, logic [127:0] d, logic [25:0] l,
                         logic [4:0] w, logic [31:0] m, string req);
    @(negedge clk);
    rsp_valid = 1; rsp_tag = tag; rsp_data = d;
    @(negedge clk);
    rsp_valid = 0;
    chk("R6", "fill_we", fill_we, 1);
    chk({"R6 ", req}, "fill_line", fill_line, l);
    chk("R6", "fill_data", fill_data, d);
    @(negedge clk);
    chk("R7", "replay_valid", replay_valid, 1);
    chk({"R7 ", req}, "replay_warp", replay_warp, w);
    chk({"R7 ", req}, "replay_mask", replay_mask, m);
    chk("R7", "miss_ready after free", miss_ready, 1);
    @(negedge clk);
    chk("R7", "replay pulse ended", replay_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", "miss_ready", miss_ready, 1);
    chk("R1", "req_valid", req_valid, 0);
    chk("R1", "fill_we", fill_we, 0);
    chk("R1", "replay_valid", replay_valid, 0);
  endtask

  task automatic t_store();
    send_miss(26'h55, 5'd1, 32'hF, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R8", "req_valid after store", req_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_single();
    send_miss(26'h100, 5'd3, 32'h0000_00F0, 0);
    take_req(26'h100, 2'd0, "R2 R8 entry 0 free");
    chk("R2", "req_valid after accept", req_valid, 0);
    respond(2'd0, 128'hDEAD_BEEF_0123, 26'h100, 5'd3, 32'h0000_00F0, "single");
  endtask

  task automatic t_merge();
    send_miss(26'h200, 5'd7, 32'h1, 0);
    send_miss(26'h200, 5'd7, 32'h4, 0);
    take_req(26'h200, 2'd0, "R3");
    chk("R3", "no second request", req_valid, 0);
    respond(2'd0, 128'h77, 26'h200, 5'd7, 32'h5, "merged mask");
  endtask

  task automatic t_full_order();
    send_miss(26'hA0, 5'd10, 32'h1, 0);
    send_miss(26'hB0, 5'd11, 32'h2, 0);
    send_miss(26'hC0, 5'd12, 32'h4, 0);
    send_miss(26'hD0, 5'd13, 32'h8, 0);
    chk("R4", "miss_ready full", miss_ready, 0);
    miss_valid = 1; miss_line = 26'hE0; miss_warp = 5'd14; miss_mask = 32'h10;
    @(negedge clk);
    @(negedge clk);
    miss_valid = 0;
    chk("R2", "req_tag held", req_tag, 0);
    take_req(26'hA0, 2'd0, "R5");
    take_req(26'hB0, 2'd1, "R5");
    take_req(26'hC0, 2'd2, "R5");
    take_req(26'hD0, 2'd3, "R5");
    chk("R4", "stalled miss not recorded", req_valid, 0);
    respond(2'd2, 128'hC, 26'hC0, 5'd12, 32'h4, "R9");
    respond(2'd0, 128'hA, 26'hA0, 5'd10, 32'h1, "R9");
    respond(2'd3, 128'hD, 26'hD0, 5'd13, 32'h8, "R9");
    respond(2'd1, 128'hB, 26'hB0, 5'd11, 32'h2, "R9");
    chk("R4", "no request after drain", req_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_store();
        t_single();
        t_merge();
        t_full_order();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule